// File: doc/BRIEF.md
# Two-Pin Interrupt and Pattern-Match Unit

This block watches two channels, each picking one pin of a 32-bit input port through its own index. The pins are synchronised and compared with their previous values to find edges. One mode bit decides which of two engines drives the outputs. In pin-interrupt mode, each channel raises its own interrupt on a chosen edge or level condition. In pattern-match mode, two bit slices test levels or transitions. Endpoint bits group the slices into product terms, and each completed term drives its own interrupt line.

When it is enabled, a single event output gives a one-cycle pulse each time a pattern match starts. All configuration arrives through a plain write port: one write-enable, a 3-bit address and 32 bits of data. Nothing is read back. The edge status is seen only on the interrupt outputs.

Top module: `pinmatch_unit`

## Requirements
- R1: After reset all outputs are 0. Channel c takes its pin from the index field at address 1, bits [8c+4:8c]. Pins that no channel selects have no effect.
- R2: The configuration of channel c sits at address 2, bits [4c+2:4c]. Bit 0 = 0 selects edge mode, where bit 1 enables rising edges and bit 2 enables falling edges. With both bits set, either edge counts. An enabled edge on the pin sets the channel's status, and pin_irq[c] shows it 3 clock edges after the pin changes.
- R3: An edge status stays set until 1 is written to bit c at address 3. That write clears the status at the write edge.
- R4: Bit 0 = 1 selects level mode. pin_irq[c] is then high 3 edges after the pin goes high (bit 1 = active-high) or goes low (bit 2 = active-low), and it falls again 3 edges after the pin leaves that level.
- R5: Address 0, bit 0 = 1 selects pattern-match mode. In that mode pin_irq is 0 and no edge status is set. In pin-interrupt mode (bit 0 = 0), term_irq and evt stay 0.
- R6: Each slice i has a 3-bit condition code at address 4, bits [3i+2:3i]. Its source channel is at bit 24+i. The codes are 0 true, 1 rise seen, 2 fall seen, 3 either edge seen, 4 high, 5 low, 6 false, and 7 edge in this cycle only. In the "seen" codes a flag latches the edge. term_irq follows the pin 3 edges after it changes.
- R7: Slice i closes a product term when its endpoint bit (address 4, bit 16+i) is set. term_irq[i] is then the AND of all slices after the previous endpoint, up to and including slice i. A slice without an endpoint raises no term of its own.
- R8: A write to address 4 clears all latched edge flags. A term that was held only by a flag drops 2 edges after the write.
- R9: With address 0, bit 1 = 1, evt pulses high for exactly one cycle when some term becomes true, at the same edge that term_irq rises. With bit 1 = 0, evt stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | 32 | Asynchronous input port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| pin_irq | output | 2 | Per-channel pin interrupt |
| term_irq | output | 2 | Per-slice product-term interrupt |
| evt | output | 1 | One-cycle match event pulse |

## Verification
A pin change passes two synchroniser flops before it reaches the edge and level registers. From there it needs one more edge before it shows on pin_irq or term_irq, so both results are due at the third rising edge after the input moves. A configuration write works at its own edge: mode gating and status clears show at once, while a flag-only term drops one edge later. The bench drives inputs on falling edges, steps the exact number of rising edges to the due edge, and samples at the next falling edge. Where it checks one-cycle results (code 7 and evt), it samples once more a single edge later to see that the pulse has gone.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    SC_TRUE    = 3'd0,
    SC_ROSE    = 3'd1,
    SC_FELL    = 3'd2,
    SC_ANYEDGE = 3'd3,
    SC_HIGH    = 3'd4,
    SC_LOW     = 3'd5,
    SC_FALSE   = 3'd6,
    SC_EVENT   = 3'd7
  } slice_code_e;

  // edge-mode hit: cfg[1] rise enable, cfg[2] fall enable
  function automatic logic edge_hit(input logic [2:0] cfg, input logic rise, input logic fall);
    return (cfg[1] & rise) | (cfg[2] & fall);
  endfunction

  // level-mode hit: cfg[1] active high, cfg[2] active low
  function automatic logic level_hit(input logic [2:0] cfg, input logic v);
    return (cfg[1] & v) | (cfg[2] & ~v);
  endfunction

  function automatic logic slice_cond(input logic [2:0] code, input logic lvl,
                                      input logic seen_r, input logic seen_f,
                                      input logic now_e);
    logic c;
    case (slice_code_e'(code))
      SC_TRUE:    c = 1'b1;
      SC_ROSE:    c = seen_r;
      SC_FELL:    c = seen_f;
      SC_ANYEDGE: c = seen_r | seen_f;
      SC_HIGH:    c = lvl;
      SC_LOW:     c = ~lvl;
      SC_FALSE:   c = 1'b0;
      default:    c = now_e;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/pm_chan.sv
module pm_chan #(
  parameter int NPINS = 32,
  parameter int IDXW  = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] port_s,
  input  logic [IDXW-1:0]  idx,
  output logic             sel,
  output logic             rise,
  output logic             fall
);
  logic prev_q;

  assign sel  = port_s[idx];
  assign rise = sel & ~prev_q;
  assign fall = ~sel & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sel;
  end
endmodule

// File: rtl/pm_pin_irq.sv
module pm_pin_irq
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match_mode,
  input  logic [2:0] cfg,
  input  logic       sel,
  input  logic       rise,
  input  logic       fall,
  input  logic       clr,
  output logic       irq,
  output logic       st
);
  logic lvl_q;
  logic set_now;

  assign set_now = ~match_mode & ~cfg[0] & edge_hit(cfg, rise, fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      st    <= (st & ~clr) | set_now;
      lvl_q <= level_hit(cfg, sel);
    end
  end

  assign irq = ~match_mode & (cfg[0] ? lvl_q : st);
endmodule

// File: rtl/pm_matcher.sv
module pm_matcher
  import pm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int NSLICE = 2,
  parameter int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         match_mode,
  input  logic                         ev_en,
  input  logic                         slice_wr,
  input  logic [NSLICE-1:0][2:0]       code,
  input  logic [NSLICE-1:0]            ep,
  input  logic [NSLICE-1:0][CHW-1:0]   src,
  input  logic [NCH-1:0]               sel,
  input  logic [NCH-1:0]               rise,
  input  logic [NCH-1:0]               fall,
  output logic [NSLICE-1:0]            term_irq,
  output logic                         evt,
  output logic [NSLICE-1:0]            stk_r,
  output logic [NSLICE-1:0]            stk_f
);
  logic [NSLICE-1:0] cond;
  logic [NSLICE-1:0] term;
  logic              any_now;
  logic              any_q;

  // AND of slice j and every earlier slice back to the previous endpoint
  function automatic logic term_of(input logic [NSLICE-1:0] c,
                                   input logic [NSLICE-1:0] e, input int j);
    logic acc;
    logic open_run;
    acc      = e[j] & c[j];
    open_run = 1'b1;
    for (int k = 1; k < NSLICE; k++) begin
      if ((j - k) >= 0 && open_run) begin
        if (e[j-k]) open_run = 1'b0;
        else        acc = acc & c[j-k];
      end
    end
    return acc;
  endfunction

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    logic v, r, f;
    assign v = sel[src[i]];
    assign r = rise[src[i]];
    assign f = fall[src[i]];
    assign cond[i] = slice_cond(code[i], v, stk_r[i] | r, stk_f[i] | f, r | f);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stk_r[i] <= 1'b0;
        stk_f[i] <= 1'b0;
      end else if (slice_wr) begin
        stk_r[i] <= 1'b0;
        stk_f[i] <= 1'b0;
      end else begin
        stk_r[i] <= stk_r[i] | r;
        stk_f[i] <= stk_f[i] | f;
      end
    end

    assign term[i] = term_of(cond, ep, i);
  end

  assign any_now = match_mode & (|term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_irq <= '0;
      any_q    <= 1'b0;
      evt      <= 1'b0;
    end else begin
      term_irq <= match_mode ? term : '0;
      any_q    <= any_now;
      evt      <= ev_en & any_now & ~any_q;
    end
  end
endmodule

// File: rtl/pinmatch_unit.sv
module pinmatch_unit #(
  parameter int NPINS  = 32,
  parameter int NCH    = 2,
  parameter int NSLICE = 2,
  parameter int AW     = 3,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [NCH-1:0]    pin_irq,
  output logic [NSLICE-1:0] term_irq,
  output logic              evt
);
  localparam int IDXW = $clog2(NPINS);
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] A_MODE  = AW'(0);
  localparam logic [AW-1:0] A_SEL   = AW'(1);
  localparam logic [AW-1:0] A_PCFG  = AW'(2);
  localparam logic [AW-1:0] A_CLR   = AW'(3);
  localparam logic [AW-1:0] A_SLICE = AW'(4);

  logic                       match_mode;
  logic                       ev_en;
  logic [NCH-1:0][IDXW-1:0]   idx_q;
  logic [NCH-1:0][2:0]        pcfg_q;
  logic [NSLICE-1:0][2:0]     code_q;
  logic [NSLICE-1:0]          ep_vec;
  logic [NSLICE-1:0][CHW-1:0] src_q;
  logic [NCH-1:0]             clr_vec;
  logic                       slice_wr;
  logic [NPINS-1:0]           port_s;
  logic [NCH-1:0]             sel, rise, fall;
  logic [NCH-1:0]             edge_st;
  logic [NSLICE-1:0]          stk_r, stk_f;
  logic                       stk_any;
  logic                       cfg_unused;

  assign cfg_unused = ^cfg_wdata;
  assign clr_vec    = (cfg_we && cfg_addr == A_CLR) ? cfg_wdata[NCH-1:0] : '0;
  assign slice_wr   = cfg_we && cfg_addr == A_SLICE;
  assign stk_any    = |{stk_r, stk_f};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_mode <= 1'b0;
      ev_en      <= 1'b0;
      idx_q      <= '0;
      pcfg_q     <= '0;
      code_q     <= '0;
      ep_vec     <= '0;
      src_q      <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_MODE: begin
          match_mode <= cfg_wdata[0];
          ev_en      <= cfg_wdata[1];
        end
        A_SEL:
          for (int c = 0; c < NCH; c++) idx_q[c] <= cfg_wdata[8*c +: IDXW];
        A_PCFG:
          for (int c = 0; c < NCH; c++) pcfg_q[c] <= cfg_wdata[4*c +: 3];
        A_SLICE:
          for (int i = 0; i < NSLICE; i++) begin
            code_q[i] <= cfg_wdata[3*i +: 3];
            ep_vec[i] <= cfg_wdata[16+i];
            src_q[i]  <= cfg_wdata[24+CHW*i +: CHW];
          end
        default: ;
      endcase
    end
  end

  pm_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(port_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pm_chan #(.NPINS(NPINS), .IDXW(IDXW)) u_chan (
      .clk(clk), .rst_n(rst_n), .port_s(port_s), .idx(idx_q[c]),
      .sel(sel[c]), .rise(rise[c]), .fall(fall[c])
    );
    pm_pin_irq u_pirq (
      .clk(clk), .rst_n(rst_n), .match_mode(match_mode), .cfg(pcfg_q[c]),
      .sel(sel[c]), .rise(rise[c]), .fall(fall[c]), .clr(clr_vec[c]),
      .irq(pin_irq[c]), .st(edge_st[c])
    );
  end

  pm_matcher #(.NCH(NCH), .NSLICE(NSLICE), .CHW(CHW)) u_match (
    .clk(clk), .rst_n(rst_n), .match_mode(match_mode), .ev_en(ev_en),
    .slice_wr(slice_wr), .code(code_q), .ep(ep_vec), .src(src_q),
    .sel(sel), .rise(rise), .fall(fall),
    .term_irq(term_irq), .evt(evt), .stk_r(stk_r), .stk_f(stk_f)
  );
endmodule

// File: rtl/pinmatch_unit_chk.sv
module pinmatch_unit_chk #(
  parameter int NCH    = 2,
  parameter int NSLICE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              match_mode,
  input logic [NCH-1:0]    pin_irq,
  input logic [NSLICE-1:0] term_irq,
  input logic              evt,
  input logic [NCH-1:0]    edge_st,
  input logic [NCH-1:0]    clr_vec,
  input logic              slice_wr,
  input logic              stk_any,
  input logic [NSLICE-1:0] ep_vec
);
  // R5: pin interrupts silent in pattern-match mode
  p_pin_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_mode |-> pin_irq == '0);

  // R5: term and event outputs silent once pin mode has held a cycle
  p_match_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_mode && !$past(match_mode)) |-> (term_irq == '0 && !evt));

  // R9: event is a single-cycle pulse
  p_evt_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  // R8: slice write clears all latched edge flags
  p_sticky_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slice_wr |=> !stk_any);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R3: status held unless cleared
    p_status_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_st[c] && !clr_vec[c]) |=> edge_st[c]);
    // R5: status never newly set in pattern-match mode
    p_status_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(edge_st[c]) |-> !$past(match_mode));
  end

  for (genvar j = 0; j < NSLICE; j++) begin : g_t
    // R7: a term fires only from a slice with its endpoint set
    p_term_endpoint_r7: assert property (@(posedge clk) disable iff (!rst_n)
      term_irq[j] |-> $past(ep_vec[j]));
  end
endmodule

bind pinmatch_unit pinmatch_unit_chk #(.NCH(NCH), .NSLICE(NSLICE)) u_chk (
  .clk(clk), .rst_n(rst_n), .match_mode(match_mode), .pin_irq(pin_irq),
  .term_irq(term_irq), .evt(evt), .edge_st(edge_st), .clr_vec(clr_vec),
  .slice_wr(slice_wr), .stk_any(stk_any), .ep_vec(ep_vec)
);

// File: tb/pinmatch_unit_test.sv
module pinmatch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  pin_irq, term_irq;
  logic        evt;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  pinmatch_unit uut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_irq(pin_irq), .term_irq(term_irq), .evt(evt)
  );

  always #4 clk = ~clk;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // condition value from the code list of the requirement on slices
  function automatic logic code_val(input int code, input logic lvl, input logic sr,
                                    input logic sf, input logic now_e);
    case (code)
      0: return 1'b1;
      1: return sr;
      2: return sf;
      3: return sr | sf;
      4: return lvl;
      5: return !lvl;
      6: return 1'b0;
      default: return now_e;
    endcase
  endfunction

  // two-slice product terms per the endpoint rule (codes 4/5 only)
  function automatic logic [1:0] terms_exp(input logic [1:0] lvlcode, input logic [1:0] ep,
                                           input logic [1:0] v);
    logic c0, c1;
    c0 = lvlcode[0] ? !v[0] : v[0];
    c1 = lvlcode[1] ? !v[1] : v[1];
    return {ep[1] & c1 & (ep[0] | c0), ep[0] & c0};
  endfunction

  function automatic logic [31:0] slice_word(input int c0, input int c1,
                                             input logic [1:0] ep, input logic [1:0] src);
    return 32'(c0) | (32'(c1) << 3) | (32'(ep) << 16) | (32'(src) << 24);
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic prev_b, exp_st, b, re, fe;
    int unsigned rv;
    rv = $urandom(32'd20240611);
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 reset outputs", {29'd0, pin_irq, term_irq[0] | term_irq[1], evt}, 0);

    // R1: ch0 <- pin 5, ch1 <- pin 17; R2: ch0 rise, ch1 fall
    wr(3'd1, 32'h0000_1105);
    wr(3'd2, 32'h0000_0042);
    step(3);
    pins[4] = 1'b1; step(3);
    chk("R1 unselected pin ignored", pin_irq, 2'b00);
    pins[5] = 1'b1; step(2);
    chk("R2 not yet at edge 2", pin_irq, 2'b00);
    step(1);
    chk("R2 rise on ch0 at edge 3", pin_irq, 2'b01);
    pins[17] = 1'b1; step(3);
    chk("R2 rise ignored on fall-only ch1", pin_irq, 2'b01);
    pins[17] = 1'b0; step(3);
    chk("R2 fall on ch1", pin_irq, 2'b11);
    pins[5] = 1'b0; pins[4] = 1'b0; step(3);
    chk("R3 status held", pin_irq, 2'b11);
    wr(3'd3, 32'h1);
    chk("R3 clear ch0 only", pin_irq, 2'b10);
    wr(3'd3, 32'h2);
    chk("R3 clear ch1", pin_irq, 2'b00);

    // R2/R3 random edges on ch0
    prev_b = 1'b0; exp_st = 1'b0;
    for (int it = 0; it < 60; it++) begin
      re = 1'($urandom % 2); fe = 1'($urandom % 2);
      wr(3'd2, {29'd0, fe, re, 1'b0});
      b = 1'($urandom % 2);
      pins[5] = b; step(3);
      if ((b && !prev_b && re) || (!b && prev_b && fe)) exp_st = 1'b1;
      chk("R2 random edge status", pin_irq[0], exp_st);
      if ($urandom % 3 == 0) begin
        wr(3'd3, 32'h1); exp_st = 1'b0;
        chk("R3 random clear", pin_irq[0], exp_st);
      end
      prev_b = b;
    end
    wr(3'd3, 32'h3);

    // R4 level modes on ch0
    pins[5] = 1'b0;
    wr(3'd2, 32'h3); step(3);
    chk("R4 active-high idle", pin_irq[0], 1'b0);
    pins[5] = 1'b1; step(3);
    chk("R4 active-high asserted", pin_irq[0], 1'b1);
    pins[5] = 1'b0; step(3);
    chk("R4 active-high released", pin_irq[0], 1'b0);
    wr(3'd2, 32'h5); step(1);
    chk("R4 active-low asserted", pin_irq[0], 1'b1);
    pins[5] = 1'b1; step(3);
    chk("R4 active-low released", pin_irq[0], 1'b0);

    // R5 mode exclusivity
    wr(3'd2, 32'h3); step(1);
    chk("R5 level high in pin mode", pin_irq[0], 1'b1);
    wr(3'd0, 32'h1);
    chk("R5 pin_irq off in match mode", pin_irq, 2'b00);
    wr(3'd2, 32'h2); pins[5] = 1'b0; step(3);
    pins[5] = 1'b1; step(3);
    wr(3'd0, 32'h0);
    chk("R5 no status set in match mode", pin_irq, 2'b00);
    wr(3'd4, slice_word(0, 6, 2'b01, 2'b10)); step(3);
    chk("R5 no terms in pin mode", {30'd0, term_irq}, 0);
    chk("R5 no evt in pin mode", evt, 1'b0);

    // R6 each condition code on slice 0 (slice 1 false)
    wr(3'd0, 32'h1);
    pins[5] = 1'b0; step(3);
    for (int code = 0; code < 8; code++) begin
      wr(3'd4, slice_word(code, 6, 2'b11, 2'b10));
      step(3);
      chk($sformatf("R6 code %0d idle", code), term_irq, {1'b0, code_val(code, 0, 0, 0, 0)});
      pins[5] = 1'b1; step(3);
      chk($sformatf("R6 code %0d at rise", code), term_irq, {1'b0, code_val(code, 1, 1, 0, 1)});
      step(1);
      chk($sformatf("R6 code %0d after rise", code), term_irq, {1'b0, code_val(code, 1, 1, 0, 0)});
      pins[5] = 1'b0; step(3);
      chk($sformatf("R6 code %0d at fall", code), term_irq, {1'b0, code_val(code, 0, 1, 1, 1)});
      step(1);
    end

    // R8 sticky cleared by slice write
    wr(3'd4, slice_word(1, 6, 2'b01, 2'b10)); step(2);
    pins[5] = 1'b1; step(3);
    chk("R8 rise flag holds term", term_irq[0], 1'b1);
    wr(3'd4, slice_word(1, 6, 2'b01, 2'b10));
    step(1);
    chk("R8 flag cleared by write", term_irq[0], 1'b0);
    pins[5] = 1'b0; step(3);

    // R7 endpoint grouping directed
    pins[17] = 1'b0;
    wr(3'd4, slice_word(4, 4, 2'b10, 2'b10));
    for (int v = 0; v < 4; v++) begin
      pins[5] = v[0]; pins[17] = v[1]; step(3);
      chk($sformatf("R7 chained term v=%0d", v), term_irq, {v == 3, 1'b0});
    end
    // R7 random codes, endpoints and pin levels
    for (int it = 0; it < 40; it++) begin
      logic [1:0] lc, ep, v;
      lc = 2'($urandom); ep = 2'($urandom); v = 2'($urandom);
      wr(3'd4, slice_word(lc[0] ? 5 : 4, lc[1] ? 5 : 4, ep, 2'b10));
      pins[5] = v[0]; pins[17] = v[1]; step(3);
      chk("R7 random terms", term_irq, terms_exp(lc, ep, v));
    end

    // R9 event pulse
    pins[5] = 1'b0; pins[17] = 1'b0;
    wr(3'd4, slice_word(4, 6, 2'b11, 2'b10));
    wr(3'd0, 32'h3); step(3);
    chk("R9 no evt while idle", evt, 1'b0);
    pins[5] = 1'b1; step(3);
    chk("R9 evt with term", {term_irq[0], evt}, 2'b11);
    step(1);
    chk("R9 evt one cycle", {term_irq[0], evt}, 2'b10);
    pins[5] = 1'b0; step(3);
    wr(3'd0, 32'h1);
    pins[5] = 1'b1; step(3);
    chk("R9 evt disabled", {term_irq[0], evt}, 2'b10);
    step(1);
    chk("R9 evt stays low", evt, 1'b0);

    done = 1'b1;
    summary();
  end
endmodule